// File: doc/BRIEF.md
# Floating-Point Control Register with Alias Views

This block holds the 32-bit control and status word of a floating-point unit, next to a fixed, read-only implementation identifier. Software reaches both through a 5-bit control-register index. Index 31 gives the whole status word. Three alias indices, 25, 26 and 28, each gather one scattered group of status fields into a compact view. A write through an alias changes only the bits that alias covers and keeps every other bit.

Each access presents an index, write data and a write-enable. Read data is combinational from the current state and the index. A write commits on the next rising clock edge. An index that maps to nothing raises an invalid flag in the same cycle, and so does a write to the read-only identifier. Such an access changes no state.

Top module: `fpctl_alias_regs`

## Requirements
- R1: Index 0 reads the implementation identifier (parameter IMPL_ID, default 32'h0003_0B20). A read of index 0 does not raise the invalid flag.
- R2: Index 31 reads the whole status word. A write through index 31 loads all 32 status bits from the write data.
- R3: A read of index 25 returns status bits 31..25 in result bits 7..1 and status bit 23 in result bit 0. All other result bits are zero.
- R4: A read of index 26 returns the status word ANDed with 32'h0003_F07C, so status bits 17..12 and 6..2 appear at their own positions.
- R5: A read of index 28 returns status bits 11..7 and 1..0 at their own positions and status bit 24 in result bit 2. All other result bits are zero.
- R6: A write through index 25 loads status bits 31..25 from data bits 7..1 and status bit 23 from data bit 0. All other status bits are kept.
- R7: A write through index 26 changes only status bits 17..12 and 6..2, taken from the same data bits. A write through index 28 changes only status bits 11..7 (from data 11..7), bit 24 (from data bit 2) and bits 1..0 (from data 1..0).
- R8: Any index other than 0, 25, 26, 28 or 31 raises the invalid flag and reads as zero. A write there leaves the status word unchanged.
- R9: A write to index 0 is ignored and raises the invalid flag. The identifier and the status word stay as they were.
- R10: Reset is synchronous and active low, and it clears the status word to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cr_idx | input | 5 | Control-register index |
| cr_wdata | input | 32 | Write data |
| cr_wr | input | 1 | Write enable; the write commits at the next rising edge |
| cr_rdata | output | 32 | Combinational read data for cr_idx |
| cr_bad | output | 1 | Invalid access: unmapped index, or a write to index 0 |

## Verification
A wrong status bit reaches the ports on the very next read. Every access is checked combinationally against a bench model, and random indices cover all four views of the word. A write mask that is too wide or too narrow only shows when a different view reads the disturbed bits, so alias writes are mixed with full-word and cross-alias reads. A bad update therefore appears within a few accesses, and directed patterns of all ones and all zeros expose each misplaced field.

// File: rtl/fpctl_pkg.sv
// Package: shared index codes, view selector type and field masks.
// Assumes a 32-bit status word. The masks follow the alias field layout.
package fpctl_pkg;
    localparam int WORD_W = 32;
    localparam int IDX_W  = 5;

    localparam logic [IDX_W-1:0] IDX_IMPL = 5'd0;
    localparam logic [IDX_W-1:0] IDX_A25  = 5'd25;
    localparam logic [IDX_W-1:0] IDX_A26  = 5'd26;
    localparam logic [IDX_W-1:0] IDX_A28  = 5'd28;
    localparam logic [IDX_W-1:0] IDX_FULL = 5'd31;

    // status-word bits each alias covers
    localparam logic [WORD_W-1:0] MASK_A25 = 32'hFE80_0000;
    localparam logic [WORD_W-1:0] MASK_A26 = 32'h0003_F07C;
    localparam logic [WORD_W-1:0] MASK_A28 = 32'h0100_0F83;

    typedef enum logic [2:0] {
        VIEW_IMPL = 3'd0,
        VIEW_A25  = 3'd1,
        VIEW_A26  = 3'd2,
        VIEW_A28  = 3'd3,
        VIEW_FULL = 3'd4,
        VIEW_NONE = 3'd5
    } view_e;
endpackage

// File: rtl/fpctl_index_decode.sv
// Index decoder: turns the index into a view selector and flags invalid
// accesses (unmapped index, or a write to the read-only identifier).
// Assumes the index is stable for the whole cycle. Purely combinational.
module fpctl_index_decode
    import fpctl_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    output view_e            view,
    output logic             bad
);
    // map index to view
    always_comb begin
        unique case (idx)
            IDX_IMPL: view = VIEW_IMPL;
            IDX_A25:  view = VIEW_A25;
            IDX_A26:  view = VIEW_A26;
            IDX_A28:  view = VIEW_A28;
            IDX_FULL: view = VIEW_FULL;
            default:  view = VIEW_NONE;
        endcase
    end

    // invalid: nothing mapped, or a write to the identifier
    always_comb begin
        bad = (view == VIEW_NONE) || (wr && view == VIEW_IMPL);
    end

    // R9: a write to index 0 is always flagged
    always_comb begin
        if (wr && idx == IDX_IMPL)
            p_impl_write_flag_r9: assert (bad);
    end
endmodule

// File: rtl/fpctl_view_read.sv
// Read mux: packs status fields into the selected view.
// Assumes view comes from fpctl_index_decode. Unmapped views read zero.
module fpctl_view_read
    import fpctl_pkg::*;
#(
    parameter logic [WORD_W-1:0] IMPL_ID = 32'h0003_0B20
) (
    input  logic [WORD_W-1:0] status,
    input  view_e             view,
    output logic [WORD_W-1:0] rdata
);
    // assemble the read value for each view
    always_comb begin
        rdata = '0;
        unique case (view)
            VIEW_IMPL: rdata = IMPL_ID;
            VIEW_A25: begin
                rdata[7:1] = status[31:25];
                rdata[0]   = status[23];
            end
            VIEW_A26:  rdata = status & MASK_A26;
            VIEW_A28: begin
                rdata[11:7] = status[11:7];
                rdata[2]    = status[24];
                rdata[1:0]  = status[1:0];
            end
            VIEW_FULL: rdata = status;
            default:   rdata = '0;
        endcase
    end

    // R3 and R5: the compact views never drive the upper bits
    always_comb begin
        if (view == VIEW_A25)
            p_a25_upper_zero_r3: assert (rdata[31:8] == '0);
        if (view == VIEW_A28)
            p_a28_upper_zero_r5: assert (rdata[31:12] == '0 && rdata[6:3] == '0);
        if (view == VIEW_NONE)
            p_none_reads_zero_r8: assert (rdata == '0);
    end
endmodule

// File: rtl/fpctl_view_write.sv
// Write unpacker: spreads the data of an alias write onto status positions
// and builds the per-bit update mask. Bits outside the mask keep their value.
// Assumes view comes from fpctl_index_decode. Purely combinational.
module fpctl_view_write
    import fpctl_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] wdata,
    input  view_e             view,
    output logic [WORD_W-1:0] nxt
);
    logic [WORD_W-1:0] val;
    logic [WORD_W-1:0] msk;

    // place write data at status positions and pick the covered bits
    always_comb begin
        val = '0;
        msk = '0;
        unique case (view)
            VIEW_A25: begin
                val[31:25] = wdata[7:1];
                val[23]    = wdata[0];
                msk        = MASK_A25;
            end
            VIEW_A26: begin
                val = wdata;
                msk = MASK_A26;
            end
            VIEW_A28: begin
                val[11:7] = wdata[11:7];
                val[24]   = wdata[2];
                val[1:0]  = wdata[1:0];
                msk       = MASK_A28;
            end
            VIEW_FULL: begin
                val = wdata;
                msk = '1;
            end
            default: begin
                val = '0;
                msk = '0;
            end
        endcase
    end

    // per-bit merge of new and kept values
    for (genvar b = 0; b < WORD_W; b++) begin : g_merge
        assign nxt[b] = msk[b] ? val[b] : cur[b];
    end
endmodule

// File: rtl/fpctl_alias_regs.sv
// Top: holds the status word and connects the decoder and both view paths.
// Assumes single-cycle accesses. Read data is combinational, and a write
// commits on the next rising edge unless the access is flagged invalid.
module fpctl_alias_regs
    import fpctl_pkg::*;
#(
    parameter logic [31:0] IMPL_ID = 32'h0003_0B20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  cr_idx,
    input  logic [31:0] cr_wdata,
    input  logic        cr_wr,
    output logic [31:0] cr_rdata,
    output logic        cr_bad
);
    view_e             view;
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] status_nxt;

    fpctl_index_decode u_dec (
        .idx  (cr_idx),
        .wr   (cr_wr),
        .view (view),
        .bad  (cr_bad)
    );

    fpctl_view_read #(.IMPL_ID(IMPL_ID)) u_rd (
        .status (status_q),
        .view   (view),
        .rdata  (cr_rdata)
    );

    fpctl_view_write u_wr (
        .cur   (status_q),
        .wdata (cr_wdata),
        .view  (view),
        .nxt   (status_nxt)
    );

    // status register: synchronous clear, valid writes only
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else if (cr_wr && !cr_bad)
            status_q <= status_nxt;
    end

    // R10: reset clears the word
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> status_q == '0);

    // R2: a full write loads the data unchanged
    p_full_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_idx == IDX_FULL) |=> status_q == $past(cr_wdata));

    // R8 and R9: flagged accesses leave the state alone
    p_bad_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_bad) |=> $stable(status_q));

    // R6: bits outside the alias-25 fields are kept
    p_a25_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_idx == IDX_A25) |=>
        (status_q & ~MASK_A25) == ($past(status_q) & ~MASK_A25));

    // R7: bits outside the alias-26 fields are kept
    p_a26_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_idx == IDX_A26) |=>
        (status_q & ~MASK_A26) == ($past(status_q) & ~MASK_A26));

    // R7: bits outside the alias-28 fields are kept
    p_a28_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cr_idx == IDX_A28) |=>
        (status_q & ~MASK_A28) == ($past(status_q) & ~MASK_A28));
endmodule

// File: tb/tb_fpctl_alias_regs.sv
`timescale 1ns/1ps
module tb_fpctl_alias_regs;
    localparam logic [31:0] ID = 32'h0003_0B20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cr_idx = '0;
    logic [31:0] cr_wdata = '0;
    logic        cr_wr = 1'b0;
    logic [31:0] cr_rdata;
    logic        cr_bad;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model = '0;

    fpctl_alias_regs #(.IMPL_ID(ID)) dut (
        .clk(clk), .rst_n(rst_n), .cr_idx(cr_idx), .cr_wdata(cr_wdata),
        .cr_wr(cr_wr), .cr_rdata(cr_rdata), .cr_bad(cr_bad)
    );

    always #2 clk = ~clk;

    function automatic logic mapped(input logic [4:0] i);
        return i == 5'd0 || i == 5'd25 || i == 5'd26 || i == 5'd28 || i == 5'd31;
    endfunction

    // expected read value, written bit by bit from the requirements
    function automatic logic [31:0] exp_rd(input logic [31:0] s, input logic [4:0] i);
        logic [31:0] r = '0;
        case (i)
            5'd0:  r = ID;
            5'd25: begin
                for (int k = 0; k < 7; k++) r[1+k] = s[25+k];
                r[0] = s[23];
            end
            5'd26: begin
                for (int k = 12; k <= 17; k++) r[k] = s[k];
                for (int k = 2; k <= 6; k++) r[k] = s[k];
            end
            5'd28: begin
                for (int k = 7; k <= 11; k++) r[k] = s[k];
                r[2] = s[24]; r[1] = s[1]; r[0] = s[0];
            end
            5'd31: r = s;
            default: r = '0;
        endcase
        return r;
    endfunction

    // expected status after a write
    function automatic logic [31:0] exp_wr(input logic [31:0] s, input logic [4:0] i,
                                           input logic [31:0] d);
        logic [31:0] n = s;
        case (i)
            5'd25: begin
                for (int k = 0; k < 7; k++) n[25+k] = d[1+k];
                n[23] = d[0];
            end
            5'd26: begin
                for (int k = 12; k <= 17; k++) n[k] = d[k];
                for (int k = 2; k <= 6; k++) n[k] = d[k];
            end
            5'd28: begin
                for (int k = 7; k <= 11; k++) n[k] = d[k];
                n[24] = d[2]; n[1] = d[1]; n[0] = d[0];
            end
            5'd31: n = d;
            default: n = s;
        endcase
        return n;
    endfunction

    function automatic string req_of(input logic [4:0] i, input logic w);
        case (i)
            5'd0:  return w ? "R9" : "R1";
            5'd25: return w ? "R6" : "R3";
            5'd26: return w ? "R7" : "R4";
            5'd28: return w ? "R7" : "R5";
            5'd31: return "R2";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // one access: drive at negedge, check outputs, then commit to the model
    task automatic access(input logic [4:0] i, input logic [31:0] d, input logic w);
        @(negedge clk);
        cr_idx = i; cr_wdata = d; cr_wr = w;
        #1;
        check(req_of(i, w), cr_rdata, exp_rd(model, i));
        check(req_of(i, w), {31'd0, cr_bad},
              {31'd0, (!mapped(i)) || (w && i == 5'd0)});
        @(posedge clk);
        if (w && mapped(i) && i != 5'd0) model = exp_wr(model, i, d);
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [4:0] list [0:4];
        void'($urandom(32'd1234));
        list[0] = 5'd0; list[1] = 5'd25; list[2] = 5'd26; list[3] = 5'd28; list[4] = 5'd31;
        // dirty the word, then reset: R10
        rst_n = 1'b1;
        @(negedge clk); cr_idx = 5'd31; cr_wdata = 32'hDEAD_BEEF; cr_wr = 1'b1;
        @(negedge clk); cr_wr = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        cr_idx = 5'd31; #1;
        check("R10", cr_rdata, 32'h0);
        model = '0;
        // R1 identifier
        access(5'd0, 32'h0, 1'b0);
        // R2 then views of all ones: R3 R4 R5
        access(5'd31, 32'hFFFF_FFFF, 1'b1);
        access(5'd25, 32'h0, 1'b0);
        access(5'd26, 32'h0, 1'b0);
        access(5'd28, 32'h0, 1'b0);
        // R6: clear alias-25 fields, full read shows the others kept
        access(5'd25, 32'h0, 1'b1);
        access(5'd31, 32'h0, 1'b0);
        // R7: alias 26 and 28 writes from a zero word
        access(5'd31, 32'h0, 1'b1);
        access(5'd26, 32'hFFFF_FFFF, 1'b1);
        access(5'd31, 32'h0, 1'b0);
        access(5'd28, 32'hFFFF_FFFF, 1'b1);
        access(5'd31, 32'h0, 1'b0);
        // R9: write to identifier ignored
        access(5'd0, 32'h1234_5678, 1'b1);
        access(5'd0, 32'h0, 1'b0);
        access(5'd31, 32'h0, 1'b0);
        // R8: unmapped indices
        access(5'd1, 32'hFFFF_FFFF, 1'b1);
        access(5'd30, 32'h0, 1'b1);
        access(5'd27, 32'h0, 1'b0);
        access(5'd31, 32'h0, 1'b0);
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [4:0] i;
            if ($urandom_range(3) == 0) i = 5'($urandom_range(31));
            else i = list[$urandom_range(4)];
            access(i, $urandom(), 1'($urandom_range(1)));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule